// File: doc/BRIEF.md
# Supply Guard Sequencer

This block sits between a host bus and a battery-backed memory array and decides, from three digitized supply-monitor flags, whether the array may be touched. The flags report whether the supply is above the operating level, below the write-protect trip level, and below the backup switchover level. Each flag is resynchronized and filtered before it can move the state machine. Once protection engages, all host strobes are blocked, read data is not driven, and a backup-source select is raised when the supply sinks under the switchover level.

When the supply returns, access is not re-enabled at once. The sequencer waits for the operating flag and then counts a recovery window of clock cycles. The window runs only while the host keeps its select and write strobes idle; any strobe restarts it, and any new dip sends the block back to protection. A host cycle that is active at the moment protection engages is cut off and reported with a one-cycle error pulse.

Top module: `supply_guard`

## Requirements
- R1: While reset is held and right after it, write protection is on (`wr_prot_o`=1), access is off (`access_en_o`=0), backup select is off and no abort is flagged.
- R2: Each supply flag goes through a two-flop synchronizer and a filter of DEB_CYC cycles; a flag change held steady reaches the outputs exactly DEB_CYC+3 clock edges after it is applied, and a pulse of DEB_CYC-1 cycles has no effect.
- R3: In normal operation, a trip flag (`supply_trip_async_i`=1) or a switchover flag turns write protection on and access off.
- R4: While access is off, `mem_sel_o`, `mem_wr_o`, `mem_rd_o` and `bus_oe_o` stay 0 and `bus_rdata_o` is all zeros, whatever the host drives.
- R5: The switchover flag (`supply_low_async_i`=1) raises `batt_sel_o`; when it clears, backup select drops but protection stays on.
- R6: Access returns only after the trip flag is clear, the operating flag (`supply_ok_async_i`=1) is set, and then REC_CYC further quiet clock edges have passed in recovery.
- R7: A host select or write strobe during recovery restarts the recovery count from zero.
- R8: A trip during recovery returns the block to protection and the full recovery window is counted again afterwards.
- R9: If `host_sel_i` is high in the first cycle after access is withdrawn, `abort_o` is 1 for exactly that cycle.
- R10: With access on, `mem_sel_o`=sel, `mem_wr_o`=sel&wr, `mem_rd_o`=sel&rd&!wr, `bus_oe_o`=`mem_rd_o`, and `bus_rdata_o` passes `mem_rdata_i` when driven, else zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_async_i | input | 1 | Supply above operating level (asynchronous) |
| supply_trip_async_i | input | 1 | Supply below write-protect trip (asynchronous) |
| supply_low_async_i | input | 1 | Supply below backup switchover (asynchronous) |
| host_sel_i | input | 1 | Host chip select, active high |
| host_wr_i | input | 1 | Host write strobe, active high |
| host_rd_i | input | 1 | Host output enable, active high |
| mem_rdata_i | input | DW | Read data from the array |
| mem_sel_o | output | 1 | Gated select to the array |
| mem_wr_o | output | 1 | Gated write to the array |
| mem_rd_o | output | 1 | Gated read to the array |
| bus_rdata_o | output | DW | Read data to the host, zero when not driven |
| bus_oe_o | output | 1 | Host data bus drive enable; 0 means high impedance |
| wr_prot_o | output | 1 | Write protection active |
| batt_sel_o | output | 1 | Backup energy source selected |
| access_en_o | output | 1 | Array access allowed |
| abort_o | output | 1 | Host cycle cut off by protection |

## Verification
The collision that matters is a supply trip landing while a host write is in flight: gating and the abort report fall in the same cycle. The bench holds a write active, raises the trip flag, and checks that the write still passes one edge before the computed latency and is blocked, with the abort pulse, exactly at it. A second collision, a host strobe arriving mid-recovery, is provoked by a one-cycle select pulse and judged by the exact edge at which access returns.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_PROTECT = 2'd1,
    ST_BACKUP  = 2'd2,
    ST_RECOVER = 2'd3
  } guard_state_e;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_OK   = 0;
  localparam int unsigned FLAG_TRIP = 1;
  localparam int unsigned FLAG_LOW  = 2;
  // reset values assume a supply that is not yet trusted
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 3'b010;
endpackage

// File: rtl/flag_filter.sv
module flag_filter #(
  parameter int unsigned DEB_CYC = 3,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

  logic          s1_q, s2_q, flt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  // flip only after DEB_CYC consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= RST_VAL;
      cnt_q <= '0;
    end else if (s2_q != flt_q) begin
      if (cnt_q == CW'(DEB_CYC - 1)) begin
        flt_q <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
  import supply_guard_pkg::*;
#(
  parameter int unsigned REC_CYC = 200000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ok_i,
  input  logic         trip_i,
  input  logic         low_i,
  input  logic         host_busy_i,
  output guard_state_e state_o
);
  localparam int unsigned CW = $clog2(REC_CYC + 1);

  guard_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          window_done;

  assign window_done = (cnt_q == CW'(REC_CYC - 1)) && !host_busy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL:  if (trip_i || low_i) state_d = ST_PROTECT;
      ST_PROTECT: begin
        if (low_i)               state_d = ST_BACKUP;
        else if (ok_i && !trip_i) state_d = ST_RECOVER;
      end
      ST_BACKUP:  if (!low_i) state_d = ST_PROTECT;
      ST_RECOVER: begin
        if (low_i || trip_i || !ok_i) state_d = ST_PROTECT;
        else if (window_done)         state_d = ST_NORMAL;
      end
      default:    state_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PROTECT;
    else         state_q <= state_d;
  end

  // recovery window, restarted by any host strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (state_q != ST_RECOVER) cnt_q <= '0;
    else if (host_busy_i)           cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign state_o = state_q;
endmodule

// File: rtl/access_gate.sv
module access_gate #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          host_sel_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_sel_o,
  output logic          mem_wr_o,
  output logic          mem_rd_o,
  output logic [DW-1:0] bus_rdata_o,
  output logic          bus_oe_o,
  output logic          abort_o
);
  logic en_q;
  logic rd_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  // write strobe wins over output enable
  assign rd_en       = en_i && host_sel_i && host_rd_i && !host_wr_i;
  assign mem_sel_o   = en_i && host_sel_i;
  assign mem_wr_o    = en_i && host_sel_i && host_wr_i;
  assign mem_rd_o    = rd_en;
  assign bus_oe_o    = rd_en;
  assign bus_rdata_o = rd_en ? mem_rdata_i : '0;
  assign abort_o     = en_q && !en_i && host_sel_i;
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned DEB_CYC = 3,
  parameter int unsigned REC_CYC = 200000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          supply_ok_async_i,
  input  logic          supply_trip_async_i,
  input  logic          supply_low_async_i,
  input  logic          host_sel_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_sel_o,
  output logic          mem_wr_o,
  output logic          mem_rd_o,
  output logic [DW-1:0] bus_rdata_o,
  output logic          bus_oe_o,
  output logic          wr_prot_o,
  output logic          batt_sel_o,
  output logic          access_en_o,
  output logic          abort_o
);
  logic [NUM_FLAGS-1:0] raw_flags, flt_flags;
  guard_state_e         state;

  assign raw_flags[FLAG_OK]   = supply_ok_async_i;
  assign raw_flags[FLAG_TRIP] = supply_trip_async_i;
  assign raw_flags[FLAG_LOW]  = supply_low_async_i;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flt
    flag_filter #(
      .DEB_CYC (DEB_CYC),
      .RST_VAL (FLAG_RST[i])
    ) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_flags[i]),
      .flt_o  (flt_flags[i])
    );
  end

  guard_fsm #(.REC_CYC(REC_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ok_i        (flt_flags[FLAG_OK]),
    .trip_i      (flt_flags[FLAG_TRIP]),
    .low_i       (flt_flags[FLAG_LOW]),
    .host_busy_i (host_sel_i || host_wr_i),
    .state_o     (state)
  );

  assign access_en_o = (state == ST_NORMAL);
  assign wr_prot_o   = (state != ST_NORMAL);
  assign batt_sel_o  = (state == ST_BACKUP);

  access_gate #(.DW(DW)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (access_en_o),
    .host_sel_i  (host_sel_i),
    .host_wr_i   (host_wr_i),
    .host_rd_i   (host_rd_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_sel_o   (mem_sel_o),
    .mem_wr_o    (mem_wr_o),
    .mem_rd_o    (mem_rd_o),
    .bus_rdata_o (bus_rdata_o),
    .bus_oe_o    (bus_oe_o),
    .abort_o     (abort_o)
  );
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_sel_i,
  input logic          host_wr_i,
  input logic          mem_sel_o,
  input logic          mem_wr_o,
  input logic          mem_rd_o,
  input logic [DW-1:0] bus_rdata_o,
  input logic          bus_oe_o,
  input logic          wr_prot_o,
  input logic          batt_sel_o,
  input logic          access_en_o,
  input logic          abort_o
);
  // R4
  gate_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_en_o |-> (!mem_sel_o && !mem_wr_o && !mem_rd_o && !bus_oe_o));

  // R4
  bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> (bus_rdata_o == '0));

  // R5
  batt_prot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batt_sel_o |-> wr_prot_o);

  // R5
  batt_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(batt_sel_o) |-> !access_en_o);

  // R7
  resume_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(access_en_o) |-> $past(!host_sel_i && !host_wr_i));

  // R9
  abort_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (wr_prot_o && host_sel_i));

  // R9
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
endmodule

bind supply_guard supply_guard_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_sel_i  (host_sel_i),
  .host_wr_i   (host_wr_i),
  .mem_sel_o   (mem_sel_o),
  .mem_wr_o    (mem_wr_o),
  .mem_rd_o    (mem_rd_o),
  .bus_rdata_o (bus_rdata_o),
  .bus_oe_o    (bus_oe_o),
  .wr_prot_o   (wr_prot_o),
  .batt_sel_o  (batt_sel_o),
  .access_en_o (access_en_o),
  .abort_o     (abort_o)
);

// File: tb/supply_guard_bench.sv
module supply_guard_bench;
  localparam int unsigned DW  = 8;
  localparam int unsigned DEB = 3;
  localparam int unsigned REC = 16;
  localparam int unsigned LAT = DEB + 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ok_a = 1'b1, trip_a = 1'b0, low_a = 1'b0;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] rdata_in = '0;
  logic mem_sel, mem_wr, mem_rd, bus_oe, wr_prot, batt_sel, acc_en, abort_p;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  supply_guard #(.DW(DW), .DEB_CYC(DEB), .REC_CYC(REC)) u_supply_guard (
    .clk_i               (clk),
    .rst_ni              (rst_ni),
    .supply_ok_async_i   (ok_a),
    .supply_trip_async_i (trip_a),
    .supply_low_async_i  (low_a),
    .host_sel_i          (sel),
    .host_wr_i           (wr),
    .host_rd_i           (rd),
    .mem_rdata_i         (rdata_in),
    .mem_sel_o           (mem_sel),
    .mem_wr_o            (mem_wr),
    .mem_rd_o            (mem_rd),
    .bus_rdata_o         (bus_rdata),
    .bus_oe_o            (bus_oe),
    .wr_prot_o           (wr_prot),
    .batt_sel_o          (batt_sel),
    .access_en_o         (acc_en),
    .abort_o             (abort_p)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(input string req, input bit open);
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 4; d++) begin
        logic [DW-1:0] v;
        logic e_rd;
        v = DW'(8'h3C ^ (d * 8'h55));
        {sel, wr, rd} = c[2:0];
        rdata_in = v;
        #1;
        e_rd = open && sel && rd && !wr;
        chk({req, " sel"}, mem_sel, open && sel);
        chk({req, " wr"}, mem_wr, open && sel && wr);
        chk({req, " rd"}, mem_rd, e_rd);
        chk({req, " oe"}, bus_oe, e_rd);
        chk({req, " data"}, bus_rdata, e_rd ? v : '0);
      end
    end
    {sel, wr, rd} = 3'b000;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 prot", wr_prot, 1);
    chk("R1 acc", acc_en, 0);
    chk("R1 batt", batt_sel, 0);
    chk("R1 abort", abort_p, 0);
    rst_ni = 1'b1;
    step(1);
    chk("R1 prot after release", wr_prot, 1);
    // R6 first power-up: recovery entered at edge LAT, access after REC more
    step(LAT + REC - 2);
    chk("R6 early", acc_en, 0);
    step(1);
    chk("R6 resume", acc_en, 1);

    // R10 open sweep
    sweep("R10", 1'b1);

    // R2 short pulse ignored
    trip_a = 1'b1;
    step(DEB - 1);
    trip_a = 1'b0;
    step(10);
    chk("R2 glitch", acc_en, 1);

    // R3 + R9 trip during host write
    sel = 1'b1; wr = 1'b1; trip_a = 1'b1;
    step(LAT - 1);
    chk("R2 latency acc", acc_en, 1);
    chk("R3 write still open", mem_wr, 1);
    step(1);
    chk("R3 prot", wr_prot, 1);
    chk("R3 acc", acc_en, 0);
    chk("R4 write blocked", mem_wr, 0);
    chk("R9 abort", abort_p, 1);
    step(1);
    chk("R9 abort one cycle", abort_p, 0);
    sel = 1'b0; wr = 1'b0;

    // R4 closed sweep
    sweep("R4", 1'b0);

    // R5 backup
    low_a = 1'b1; ok_a = 1'b0;
    step(LAT - 1);
    chk("R5 batt early", batt_sel, 0);
    step(1);
    chk("R5 batt", batt_sel, 1);
    chk("R5 prot", wr_prot, 1);
    low_a = 1'b0;
    step(LAT);
    chk("R5 batt off", batt_sel, 0);
    chk("R5 still prot", wr_prot, 1);

    // R6 no resume without operating flag
    trip_a = 1'b0;
    step(30);
    chk("R6 ok missing", acc_en, 0);
    ok_a = 1'b1;
    step(LAT);
    // R7 strobe restarts recovery
    step(8);
    sel = 1'b1;
    #1;
    chk("R4 sel blocked in recovery", mem_sel, 0);
    step(1);
    sel = 1'b0;
    step(REC - 1);
    chk("R7 restart early", acc_en, 0);
    step(1);
    chk("R7 resume", acc_en, 1);

    // R8 dip during recovery
    trip_a = 1'b1;
    step(LAT);
    trip_a = 1'b0;
    step(LAT);
    step(6);
    trip_a = 1'b1;
    step(LAT);
    chk("R8 back to prot", acc_en, 0);
    trip_a = 1'b0;
    step(LAT + REC - 1);
    chk("R8 full window early", acc_en, 0);
    step(1);
    chk("R8 resume", acc_en, 1);
    sweep("R10 after cycle", 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule